// File: doc/BRIEF.md
# Paged Register Window Decoder

This block sits between a narrow register bus driven by software and a much larger internal register file. The software-facing port can only address a 4 KB space, while the register file behind it spans 64 KB. To bridge the gap, a control register inside the block carries a page-select field. Any access that lands in the top 1 KB of the software address space is steered to the selected page of the register file. The target address is the page number followed by the low ten address bits.

Software reaches a far register in two steps. It first writes the upper six bits of the far offset into the page field. It then reads or writes the window at the far offset's low ten bits. Every other address is forwarded to the register file unchanged. The one exception is the control register itself, which the block answers locally.

The control register also holds two programmed-I/O path enables. These are driven out of the block. They keep their values across page changes as long as software writes them back as read.

Top module: `paged_window_dec`

## Requirements
- R1: After synchronous reset the control register reads back as zero, so the page is 0 and both path enables (`pio_en`) are low.
- R2: A write to address 0x808 stores page bits 18:13 and enable bits 1:0 of the write data. All other bits of the control register read back as zero whatever was written.
- R3: An access to address 0x808 is answered by the block and is never forwarded: `m_req` stays low.
- R4: An access in the window 0xC00 to 0xFFF is forwarded with `m_addr` = page × 1024 + `s_addr[9:0]`.
- R5: An access outside the window that is not to 0x808 is forwarded with `m_addr` equal to `s_addr` zero-extended to 16 bits. This includes 0x000 to 0xBFF apart from 0x808.
- R6: A page written to the control register applies to the very next access, even when that access follows with no idle cycle.
- R7: `pio_en` bit 0 (host-side path) and bit 1 (link-side path) follow control bits 0 and 1. They change only on a write to 0x808, and forwarded accesses never alter the control register.
- R8: A read request is answered in the following cycle with `s_rvalid` high and `s_rdata` holding either the control register or the register-file data. Writes and idle cycles produce no `s_rvalid`.
- R9: A forwarded access carries the write strobe and the write data through unchanged on `m_we` and `m_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_req | input | 1 | Software-side access request, one cycle per access |
| s_we | input | 1 | Software-side write strobe (1 = write, 0 = read) |
| s_addr | input | 12 | Software-side byte address |
| s_wdata | input | 32 | Software-side write data |
| s_rvalid | output | 1 | Read data valid, one cycle after a read request |
| s_rdata | output | 32 | Read data returned to software |
| m_req | output | 1 | Register-file access request |
| m_we | output | 1 | Register-file write strobe |
| m_addr | output | 16 | Register-file address after redirection |
| m_wdata | output | 32 | Register-file write data |
| m_rdata | input | 32 | Register-file read data, valid in the request cycle |
| pio_en | output | 2 | Programmed-I/O path enables from the control register |

## Verification
Addresses are chosen on both sides of each decode boundary: 0xBFF against 0xC00, 0xFFF at the window top, and 0x808 against its neighbour 0x80C. These separate the window, pass-through and local-register cases. Page values of 0, 2, 3 and 63 are used so that a page that is dropped, truncated or shifted shows up in the upper `m_addr` bits. The bench writes all ones to the control register, which exposes any bit that is stored outside the page and enable fields. Back-to-back page-write-then-window sequences distinguish a page that takes effect immediately from one that lags by a cycle. Window writes made between control-register reads show whether forwarded traffic ever disturbs the stored enables.

// File: rtl/pwd_pkg.sv
`timescale 1ns/1ps
// Package: shared decode type for the paged register window decoder.
// Assumes: every software access falls in exactly one decode class.
package pwd_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_CTRL = 2'd1,
        ACC_WIN  = 2'd2,
        ACC_PASS = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/pwd_ctrl_reg.sv
`timescale 1ns/1ps
// Module: pwd_ctrl_reg
// Holds the page-select field and the path-enable bits of the control register.
// Assumes: wr_en is a single-cycle strobe; only the stored fields are presented
// on the inputs, so bits outside them cannot be stored at all.
module pwd_ctrl_reg #(
    parameter int PAGE_W = 6,
    parameter int NUM_EN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [NUM_EN-1:0] wr_en_bits,
    output logic [PAGE_W-1:0] page_q,
    output logic [NUM_EN-1:0] en_q
);

    // Page field storage: cleared by reset, replaced on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_en) begin
            page_q <= wr_page;
        end
    end

    // One flop per enable bit, so each enable can be placed next to the logic it feeds.
    for (genvar i = 0; i < NUM_EN; i++) begin : g_en
        // Per-bit path enable: cleared by reset, loaded on a control write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[i] <= 1'b0;
            end else if (wr_en) begin
                en_q[i] <= wr_en_bits[i];
            end
        end
    end

endmodule

// File: rtl/pwd_addr_map.sv
`timescale 1ns/1ps
// Module: pwd_addr_map
// Classifies a software address and forms the register-file address.
// Assumes: the window is aligned to 2**INPAGE_W bytes and M_AW = PAGE_W + INPAGE_W.
module pwd_addr_map
    import pwd_pkg::*;
#(
    parameter int                S_AW      = 12,
    parameter int                PAGE_W    = 6,
    parameter int                INPAGE_W  = 10,
    parameter int                M_AW      = PAGE_W + INPAGE_W,
    parameter logic [S_AW-1:0]   CTRL_ADDR = 12'h808,
    parameter logic [S_AW-1:0]   WIN_BASE  = 12'hC00
) (
    input  logic              s_req,
    input  logic [S_AW-1:0]   s_addr,
    input  logic [PAGE_W-1:0] page,
    output acc_kind_e         kind,
    output logic [M_AW-1:0]   m_addr
);

    localparam int TAG_W = S_AW - INPAGE_W;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[S_AW-1:INPAGE_W];

    logic            in_window;
    logic [M_AW-1:0] pass_addr;
    logic [M_AW-1:0] win_addr;

    // Window hit: upper address bits equal the window's tag.
    always_comb begin
        in_window = (s_addr[S_AW-1:INPAGE_W] == WIN_TAG);
    end

    // Pass-through address: widen or narrow to the register-file width.
    if (M_AW > S_AW) begin : g_widen
        always_comb pass_addr = {{(M_AW-S_AW){1'b0}}, s_addr};
    end else begin : g_narrow
        always_comb pass_addr = s_addr[M_AW-1:0];
    end

    // Window address: page on top, in-page offset below.
    always_comb begin
        win_addr = {page, s_addr[INPAGE_W-1:0]};
    end

    // Access class, with the control register taking precedence.
    always_comb begin
        if (!s_req) begin
            kind = ACC_IDLE;
        end else if (s_addr == CTRL_ADDR) begin
            kind = ACC_CTRL;
        end else if (in_window) begin
            kind = ACC_WIN;
        end else begin
            kind = ACC_PASS;
        end
    end

    // Output address chosen from the class.
    always_comb begin
        m_addr = (kind == ACC_WIN) ? win_addr : pass_addr;
    end

endmodule

// File: rtl/pwd_rd_return.sv
`timescale 1ns/1ps
// Module: pwd_rd_return
// Registers read data toward software, one cycle after the read request.
// Assumes: the register file returns m_rdata combinationally in the request cycle.
module pwd_rd_return #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_fire,
    input  logic          sel_local,
    input  logic [DW-1:0] local_data,
    input  logic [DW-1:0] file_data,
    output logic          s_rvalid,
    output logic [DW-1:0] s_rdata
);

    // Valid strobe: high for exactly the cycle after each read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rvalid <= 1'b0;
        end else begin
            s_rvalid <= rd_fire;
        end
    end

    // Data capture: take local or file data on a read, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rdata <= '0;
        end else if (rd_fire) begin
            s_rdata <= sel_local ? local_data : file_data;
        end
    end

endmodule

// File: rtl/paged_window_dec.sv
`timescale 1ns/1ps
// Module: paged_window_dec (top)
// Software-facing register slave that redirects a fixed window to a selectable
// page of a larger register file and forwards all other addresses unchanged.
// Assumes: single-cycle requests, a combinational register-file read, and
// PAGE_LSB + PAGE_W <= DW with NUM_EN <= PAGE_LSB.
module paged_window_dec
    import pwd_pkg::*;
#(
    parameter int              DW        = 32,
    parameter int              S_AW      = 12,
    parameter int              PAGE_W    = 6,
    parameter int              INPAGE_W  = 10,
    parameter int              PAGE_LSB  = 13,
    parameter int              NUM_EN    = 2,
    parameter logic [S_AW-1:0] CTRL_ADDR = 12'h808,
    parameter logic [S_AW-1:0] WIN_BASE  = 12'hC00
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s_req,
    input  logic                         s_we,
    input  logic [S_AW-1:0]              s_addr,
    input  logic [DW-1:0]                s_wdata,
    output logic                         s_rvalid,
    output logic [DW-1:0]                s_rdata,
    output logic                         m_req,
    output logic                         m_we,
    output logic [PAGE_W+INPAGE_W-1:0]   m_addr,
    output logic [DW-1:0]                m_wdata,
    input  logic [DW-1:0]                m_rdata,
    output logic [NUM_EN-1:0]            pio_en
);

    localparam int M_AW = PAGE_W + INPAGE_W;

    acc_kind_e         kind;
    logic [PAGE_W-1:0] page_q;
    logic [NUM_EN-1:0] en_q;
    logic [DW-1:0]     ctrl_word;
    logic              ctrl_wr;
    logic              rd_fire;

    pwd_addr_map #(
        .S_AW      (S_AW),
        .PAGE_W    (PAGE_W),
        .INPAGE_W  (INPAGE_W),
        .M_AW      (M_AW),
        .CTRL_ADDR (CTRL_ADDR),
        .WIN_BASE  (WIN_BASE)
    ) u_map (
        .s_req  (s_req),
        .s_addr (s_addr),
        .page   (page_q),
        .kind   (kind),
        .m_addr (m_addr)
    );

    // Control-register write strobe and read strobe toward the return path.
    always_comb begin
        ctrl_wr = (kind == ACC_CTRL) && s_we;
        rd_fire = (kind != ACC_IDLE) && !s_we;
    end

    pwd_ctrl_reg #(
        .PAGE_W (PAGE_W),
        .NUM_EN (NUM_EN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_wr),
        .wr_page    (s_wdata[PAGE_LSB +: PAGE_W]),
        .wr_en_bits (s_wdata[NUM_EN-1:0]),
        .page_q     (page_q),
        .en_q       (en_q)
    );

    // Control word as software sees it: stored fields in place, zeros elsewhere.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[PAGE_LSB +: PAGE_W] = page_q;
        ctrl_word[NUM_EN-1:0]         = en_q;
    end

    // Forwarding to the register file for window and pass-through classes.
    always_comb begin
        m_req   = (kind == ACC_WIN) || (kind == ACC_PASS);
        m_we    = m_req && s_we;
        m_wdata = s_wdata;
        pio_en  = en_q;
    end

    pwd_rd_return #(
        .DW (DW)
    ) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire    (rd_fire),
        .sel_local  (kind == ACC_CTRL),
        .local_data (ctrl_word),
        .file_data  (m_rdata),
        .s_rvalid   (s_rvalid),
        .s_rdata    (s_rdata)
    );

endmodule

// File: rtl/paged_window_chk.sv
`timescale 1ns/1ps
// Module: paged_window_chk
// Port-level properties of the paged window decoder, bound to the top module.
// Assumes: the same parameter values as the instance it is bound to.
module paged_window_chk #(
    parameter int              DW        = 32,
    parameter int              S_AW      = 12,
    parameter int              PAGE_W    = 6,
    parameter int              INPAGE_W  = 10,
    parameter int              PAGE_LSB  = 13,
    parameter int              NUM_EN    = 2,
    parameter logic [S_AW-1:0] CTRL_ADDR = 12'h808,
    parameter logic [S_AW-1:0] WIN_BASE  = 12'hC00
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       s_req,
    input logic                       s_we,
    input logic [S_AW-1:0]            s_addr,
    input logic [DW-1:0]              s_wdata,
    input logic                       s_rvalid,
    input logic                       m_req,
    input logic [PAGE_W+INPAGE_W-1:0] m_addr,
    input logic [NUM_EN-1:0]          pio_en
);

    localparam int M_AW = PAGE_W + INPAGE_W;

    logic in_win;
    logic is_ctrl;
    always_comb begin
        in_win  = (s_addr[S_AW-1:INPAGE_W] == WIN_BASE[S_AW-1:INPAGE_W]);
        is_ctrl = (s_addr == CTRL_ADDR);
    end

    a_r3_ctrl_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && is_ctrl) |-> !m_req);

    a_r4_window_inpage_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && in_win) |-> (m_addr[INPAGE_W-1:0] == s_addr[INPAGE_W-1:0]));

    a_r5_passthrough_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !in_win) |-> (m_addr == M_AW'(s_addr)));

    a_r6_page_next_access: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_we && is_ctrl) |=>
        (!(s_req && in_win) || (m_addr[M_AW-1:INPAGE_W] == $past(s_wdata[PAGE_LSB +: PAGE_W]))));

    a_r7_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_req && s_we && is_ctrl) |=> $stable(pio_en));

    a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !s_we) |=> s_rvalid);

    a_r8_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_req && !s_we) |=> !s_rvalid);

endmodule

bind paged_window_dec paged_window_chk #(
    .DW        (DW),
    .S_AW      (S_AW),
    .PAGE_W    (PAGE_W),
    .INPAGE_W  (INPAGE_W),
    .PAGE_LSB  (PAGE_LSB),
    .NUM_EN    (NUM_EN),
    .CTRL_ADDR (CTRL_ADDR),
    .WIN_BASE  (WIN_BASE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_req    (s_req),
    .s_we     (s_we),
    .s_addr   (s_addr),
    .s_wdata  (s_wdata),
    .s_rvalid (s_rvalid),
    .m_req    (m_req),
    .m_addr   (m_addr),
    .pio_en   (pio_en)
);

// File: tb/paged_window_dec_tb_top.sv
`timescale 1ns/1ps
// Bench for paged_window_dec: a vector table walked by one loop, then directed
// tests for enables, back-to-back page changes and reset.
module paged_window_dec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0;
    logic        s_we = 1'b0;
    logic [11:0] s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic        s_rvalid;
    logic [31:0] s_rdata;
    logic        m_req;
    logic        m_we;
    logic [15:0] m_addr;
    logic [31:0] m_wdata;
    logic [31:0] m_rdata;
    logic [1:0]  pio_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    // Register-file model: read data tagged with the address it came from.
    assign m_rdata = {16'hA5A5, m_addr};

    paged_window_dec dut_i (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rdata(s_rdata), .m_req(m_req),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .pio_en(pio_en)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic        exp_req;
        logic [15:0] exp_addr;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h808, 32'h0,         1'b0, 16'h0000, 32'h0000_0000}, // R1 reset value
        '{1'b0, 12'hC10, 32'h0,         1'b1, 16'h0010, 32'hA5A5_0010}, // R4 page 0
        '{1'b1, 12'h808, 32'hFFFF_FFFF, 1'b0, 16'h0000, 32'h0},         // R3 local write
        '{1'b0, 12'h808, 32'h0,         1'b0, 16'h0000, 32'h0007_E003}, // R2 masked read
        '{1'b0, 12'hC04, 32'h0,         1'b1, 16'hFC04, 32'hA5A5_FC04}, // R4 page 63
        '{1'b1, 12'h400, 32'h0000_1234, 1'b1, 16'h0400, 32'h0},         // R5 R9 write
        '{1'b0, 12'hBFF, 32'h0,         1'b1, 16'h0BFF, 32'hA5A5_0BFF}, // R5 below window
        '{1'b0, 12'hFFF, 32'h0,         1'b1, 16'hFFFF, 32'hA5A5_FFFF}, // R4 window top
        '{1'b1, 12'h808, 32'h0000_4003, 1'b0, 16'h0000, 32'h0},         // R6 page 2
        '{1'b0, 12'hC00, 32'h0,         1'b1, 16'h0800, 32'hA5A5_0800}, // R6 next access
        '{1'b0, 12'h80C, 32'h0,         1'b1, 16'h080C, 32'hA5A5_080C}  // R5 ctrl neighbour
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // One access: drive at a falling edge, check forwarding, check the return next falling edge.
    task automatic access(input logic we, input logic [11:0] addr, input logic [31:0] wd,
                          input logic exp_req, input logic [15:0] exp_addr,
                          input logic [31:0] exp_rd, input string tag);
        s_req = 1'b1; s_we = we; s_addr = addr; s_wdata = wd;
        #1;
        chk({tag, " m_req"}, 32'(m_req), 32'(exp_req));
        if (exp_req) begin
            chk({tag, " m_addr"}, 32'(m_addr), 32'(exp_addr));
            chk({tag, " R9 m_we"}, 32'(m_we), 32'(we));
            if (we) chk({tag, " R9 m_wdata"}, m_wdata, wd);
        end
        @(negedge clk);
        chk({tag, " R8 s_rvalid"}, 32'(s_rvalid), 32'(!we));
        if (!we) chk({tag, " R8 s_rdata"}, s_rdata, exp_rd);
        s_req = 1'b0; s_we = 1'b0;
    endtask

    initial begin
        string vtag [NV] = '{"R1 reset read", "R4 page0 window", "R3 ctrl write",
                             "R2 ctrl mask", "R4 page63 window", "R5 low write",
                             "R5 0xBFF", "R4 0xFFF", "R6 page write",
                             "R6 back-to-back", "R5 0x80C"};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pio_en after reset", 32'(pio_en), 32'h0);
        chk("R8 no rvalid after reset", 32'(s_rvalid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].exp_req,
                   VECS[i].exp_addr, VECS[i].exp_rd, vtag[i]);
        end

        // R7: bit0 host path, bit1 link path, both set by value 0x4003.
        #1 chk("R7 enables set", 32'(pio_en), 32'h3);
        access(1'b1, 12'hC20, 32'hFFFF_FFFF, 1'b1, 16'h0820, 32'h0, "R7 window write");
        chk("R7 enables after window write", 32'(pio_en), 32'h3);
        access(1'b0, 12'h808, 32'h0, 1'b0, 16'h0, 32'h0000_4003, "R7 ctrl unchanged");
        // R7: page change written with enables as read back.
        access(1'b1, 12'h808, 32'h0000_6003, 1'b0, 16'h0, 32'h0, "R7 page3 keep en");
        access(1'b0, 12'hC00, 32'h0, 1'b1, 16'h0C00, 32'hA5A5_0C00, "R6 page3 window");
        chk("R7 enables kept", 32'(pio_en), 32'h3);
        // R2: clearing enables with the page field kept.
        access(1'b1, 12'h808, 32'h0000_6000, 1'b0, 16'h0, 32'h0, "R2 clear enables");
        #1 chk("R2 enables cleared", 32'(pio_en), 32'h0);
        @(negedge clk);
        chk("R8 idle no rvalid", 32'(s_rvalid), 32'h0);
        access(1'b0, 12'h808, 32'h0, 1'b0, 16'h0, 32'h0000_6000, "R2 readback page3");

        // R1: reset in mid-run returns page 0 and enables low.
        access(1'b1, 12'h808, 32'h0007_E003, 1'b0, 16'h0, 32'h0, "R1 preset ctrl");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 pio_en after mid reset", 32'(pio_en), 32'h0);
        access(1'b0, 12'h808, 32'h0, 1'b0, 16'h0, 32'h0, "R1 ctrl after mid reset");
        access(1'b0, 12'hC08, 32'h0, 1'b1, 16'h0008, 32'hA5A5_0008, "R1 page0 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule